// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned 4-bit operands and returns their 8-bit product through a fixed synchronous pipeline. The first register stage forms the two lowest partial products. Each later partial product is folded in by one row of one-bit full adders, and a register follows every row. The last two stages resolve the carry-save pair with a lookahead adder. That adder is cut in the middle: the low half and its carry-out are registered, and the high half is finished one cycle later. This keeps the stage delays close to equal.

The stream has no back-pressure. A new operand pair may be offered on every clock, and the flag that marks it as meaningful travels with the data. The consumer must take each result in the cycle its flag is high. The operand width is a parameter and the latency is width plus one, which is five stages at the default width.

Top module: `csa_pipe_mult`

## Requirements
- R1: For every pair of 4-bit unsigned operands, the product output equals their arithmetic product as an 8-bit unsigned number.
- R2: Reset is synchronous and active high. At the first sampling point after a clock edge that sees reset high, out_valid is 0 and the product is 0, and every operand pair still in flight is discarded.
- R3: The latency is fixed. A pair sampled with in_valid high at a rising edge is presented with out_valid high after the fifth rising edge, counting the sampling edge as the first.
- R4: A pair is accepted on every cycle with no bubbles. Consecutive pairs produce results on consecutive cycles, in arrival order.
- R5: In a cycle where in_valid is low, the operands are ignored. The matching output cycle five stages later shows out_valid low.
- R6: After each carry-save row, the registered sum vector plus the registered carry vector plus the partial products not yet added equals the full product, modulo 2^8.
- R7: The final adder takes two stages. The registered low half and carry equal the sum of the low halves of the carry-save pair. The product then equals the high halves plus that carry, placed above the low half.
- R8: While out_valid is low, the product output keeps the last result it showed, or 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks op_a/op_b as a pair to multiply this cycle |
| op_a | input | 4 | Multiplicand, unsigned |
| op_b | input | 4 | Multiplier, unsigned |
| out_valid | output | 1 | Product carries a new result this cycle |
| product | output | 8 | Unsigned product; holds while out_valid is low |

## Verification
The assertions assume that reset is applied at least once before any result is trusted. They also assume that operands are defined whenever in_valid is high. The bench holds reset high from time zero and drives only defined 4-bit values, including during idle cycles. In idle cycles the operands change on purpose, so any leak of ignored operands would show on the product. Because the block cannot be stalled, the stimulus never waits on the output: every pair, bubble and reset is scheduled on a fixed cycle, and the expected output is tied to the cycle five stages later.

// File: rtl/mult_pkg.sv
package mult_pkg;

  // default operand width of the multiplier
  parameter int unsigned MULT_W = 4;

  // one input register, one register per carry-save row, two final-adder stages
  function automatic int unsigned pipe_depth(int unsigned w);
    return w + 1;
  endfunction

endpackage

// File: rtl/csa_fa.sv
module csa_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic sum,
  output logic carry
);
  // internal rail uses active-low carries and an inverted sum; outputs restored
  logic z_n;
  logic sum_n;
  logic carry_n;

  assign z_n     = ~z;
  assign sum_n   = ~(x ^ y ^ ~z_n);
  assign carry_n = ~((x & y) | (x & ~z_n) | (y & ~z_n));
  assign sum     = ~sum_n;
  assign carry   = ~carry_n;
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] s_in,
  input  logic [DW-1:0] c_in,
  input  logic [DW-1:0] pp_in,
  output logic [DW-1:0] s_out,
  output logic [DW-1:0] c_out
);
  logic [DW-2:0] cy;

  // the carry out of the top column is beyond the product width and is dropped
  for (genvar i = 0; i < DW - 1; i++) begin : g_col
    csa_fa u_fa (
      .x    (s_in[i]),
      .y    (c_in[i]),
      .z    (pp_in[i]),
      .sum  (s_out[i]),
      .carry(cy[i])
    );
  end

  assign s_out[DW-1] = s_in[DW-1] ^ c_in[DW-1] ^ pp_in[DW-1];
  assign c_out       = {cy, 1'b0};
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   cc;
  logic         acc;
  logic         run;

  assign gen  = x & y;
  assign prop = x ^ y;

  // each carry is a flat sum of generate terms, not a ripple chain
  always_comb begin
    cc[0] = cin;
    acc   = 1'b0;
    run   = 1'b0;
    for (int i = 0; i < W; i++) begin
      acc = gen[i];
      run = prop[i];
      for (int j = i - 1; j >= 0; j--) begin
        acc = acc | (run & gen[j]);
        run = run & prop[j];
      end
      cc[i+1] = acc | (run & cin);
    end
  end

  assign sum  = prop ^ cc[W-1:0];
  assign cout = cc[W];
endmodule

// File: rtl/csa_pipe_mult.sv
module csa_pipe_mult #(
  parameter int unsigned W = mult_pkg::MULT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int unsigned DW   = 2 * W;
  localparam int unsigned ROWS = W - 2;
  localparam int unsigned LAT  = mult_pkg::pipe_depth(W);

  function automatic logic [DW-1:0] pp_of(logic [W-1:0] a, logic [W-1:0] b, int k);
    logic [DW-1:0] t;
    t = DW'(a & {W{b[k]}});
    return t << k;
  endfunction

  // sum + carry + partial products k and above must equal the full product
  function automatic logic csa_ok(logic [DW-1:0] s, logic [DW-1:0] c,
                                  logic [W-1:0] a, logic [W-1:0] b, int k);
    logic [DW-1:0] aw;
    logic [DW-1:0] full;
    logic [DW-1:0] rest;
    aw   = DW'(a);
    full = aw * DW'(b);
    rest = (aw * (DW'(b) >> k)) << k;
    return (s + c + rest) == full;
  endfunction

  // carry-save stages 0..ROWS; operands are kept only while rows still need them
  logic          st_v [0:ROWS];
  logic [DW-1:0] st_s [0:ROWS];
  logic [DW-1:0] st_c [0:ROWS];
  logic [W-1:0]  st_a [0:ROWS-1];
  logic [W-1:0]  st_b [0:ROWS-1];

  // stage 0: register the operands and the two lowest partial products
  always_ff @(posedge clk) begin
    if (rst) begin
      st_v[0] <= 1'b0;
      st_s[0] <= '0;
      st_c[0] <= '0;
      st_a[0] <= '0;
      st_b[0] <= '0;
    end else begin
      st_v[0] <= in_valid;
      st_s[0] <= pp_of(op_a, op_b, 0);
      st_c[0] <= pp_of(op_a, op_b, 1);
      st_a[0] <= op_a;
      st_b[0] <= op_b;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [DW-1:0] row_s;
    logic [DW-1:0] row_c;

    csa_row #(.DW(DW)) u_row (
      .s_in (st_s[r]),
      .c_in (st_c[r]),
      .pp_in(pp_of(st_a[r], st_b[r], r + 2)),
      .s_out(row_s),
      .c_out(row_c)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        st_v[r+1] <= 1'b0;
        st_s[r+1] <= '0;
        st_c[r+1] <= '0;
      end else begin
        st_v[r+1] <= st_v[r];
        st_s[r+1] <= row_s;
        st_c[r+1] <= row_c;
      end
    end

    if (r + 1 < ROWS) begin : g_keep
      always_ff @(posedge clk) begin
        if (rst) begin
          st_a[r+1] <= '0;
          st_b[r+1] <= '0;
        end else begin
          st_a[r+1] <= st_a[r];
          st_b[r+1] <= st_b[r];
        end
      end
    end

    // R6
    csa_invariant_chk: assert property (@(posedge clk) disable iff (rst)
      st_v[r] |-> csa_ok(st_s[r], st_c[r], st_a[r], st_b[r], r + 2));
  end

  // final adder, first half: low bits and their carry
  logic [W-1:0] lo_sum;
  logic         lo_co;
  logic         lo_v;
  logic [W-1:0] lo_q;
  logic         lo_cq;
  logic [W-1:0] hi_s_q;
  logic [W-1:0] hi_c_q;

  cla_adder #(.W(W)) u_cla_lo (
    .x   (st_s[ROWS][W-1:0]),
    .y   (st_c[ROWS][W-1:0]),
    .cin (1'b0),
    .sum (lo_sum),
    .cout(lo_co)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_v   <= 1'b0;
      lo_q   <= '0;
      lo_cq  <= 1'b0;
      hi_s_q <= '0;
      hi_c_q <= '0;
    end else begin
      lo_v   <= st_v[ROWS];
      lo_q   <= lo_sum;
      lo_cq  <= lo_co;
      hi_s_q <= st_s[ROWS][DW-1:W];
      hi_c_q <= st_c[ROWS][DW-1:W];
    end
  end

  // final adder, second half: high bits with the registered carry
  logic [W-1:0] hi_sum;
  logic         hi_co;

  cla_adder #(.W(W)) u_cla_hi (
    .x   (hi_s_q),
    .y   (hi_c_q),
    .cin (lo_cq),
    .sum (hi_sum),
    .cout(hi_co)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= lo_v;
      if (lo_v) product <= {hi_sum, lo_q};
    end
  end

  // R7
  low_half_chk: assert property (@(posedge clk) disable iff (rst)
    lo_v |-> {lo_cq, lo_q} == ({1'b0, $past(st_s[ROWS][W-1:0])} + {1'b0, $past(st_c[ROWS][W-1:0])}));

  // R7
  final_sum_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> product == {W'($past(hi_s_q) + $past(hi_c_q) + W'($past(lo_cq))), $past(lo_q)});

  // R1
  hi_carry_zero_chk: assert property (@(posedge clk) disable iff (rst)
    lo_v |-> !hi_co);

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && product == '0));

  // R8
  product_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(product));

  initial begin
    // R3
    depth_chk: assert (LAT == ROWS + 3);
  end
endmodule

// File: tb/csa_pipe_mult_test.sv
module csa_pipe_mult_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic       out_valid;
  logic [7:0] product;

  int checks = 0;
  int errors = 0;
  int t = 0;
  logic       prev_r = 1'b1;
  logic [7:0] held = '0;
  logic       hv [0:1023];
  logic [7:0] hp [0:1023];

  csa_pipe_mult #(.W(4)) uut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .out_valid(out_valid),
    .product  (product)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at step %0d actual %0d expected %0d", req, t, act, exp);
    end
  endtask

  // one cycle: check outputs at the falling edge, then drive the next inputs
  task automatic step(input logic v, input logic [3:0] a, input logic [3:0] b,
                      input logic r, input string tag);
    @(negedge clk);
    if (prev_r) begin
      check(out_valid === 1'b0, "R2 valid", int'(out_valid), 0);
      check(product === 8'd0, "R2 product", int'(product), 0);
      held = '0;
    end else if (t >= 5 && hv[t-5]) begin
      check(out_valid === 1'b1, {"R3 ", tag}, int'(out_valid), 1);
      check(product === hp[t-5], "R1/R6/R7 product", int'(product), int'(hp[t-5]));
      held = hp[t-5];
    end else begin
      check(out_valid === 1'b0, {"R5 ", tag}, int'(out_valid), 0);
      check(product === held, "R8 hold", int'(product), int'(held));
    end
    rst      = r;
    in_valid = v;
    op_a     = a;
    op_b     = b;
    hv[t]    = v && !r;
    hp[t]    = {4'b0, a} * {4'b0, b};
    if (r) begin
      for (int s = t - 4; s <= t; s++) if (s >= 0) hv[s] = 1'b0;
    end
    prev_r = r;
    t++;
  endtask

  initial begin
    #(64'd200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", t, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state (R2)
    step(1'b0, 4'd3, 4'd5, 1'b1, "R2");
    step(1'b1, 4'd7, 4'd9, 1'b1, "R2");

    // R4: every operand pair back to back (R1 exhaustive)
    for (int i = 0; i < 256; i++) step(1'b1, i[3:0], i[7:4], 1'b0, "R4");

    // R5: bubbles with changing operands in the idle cycles
    for (int i = 0; i < 90; i++) begin
      logic [3:0] a;
      logic [3:0] b;
      a = 4'((i * 7) % 16);
      b = 4'((i * 11 + 3) % 16);
      step((i % 3) != 1, a, b, 1'b0, "R5");
    end
    for (int i = 0; i < 6; i++) step(1'b0, 4'(i + 1), 4'(15 - i), 1'b0, "R5");

    // R2: reset with the pipeline full, then idle
    for (int i = 0; i < 6; i++) step(1'b1, 4'(i + 9), 4'(15 - i), 1'b0, "R4");
    step(1'b1, 4'd15, 4'd15, 1'b1, "R2");
    for (int i = 0; i < 8; i++) step(1'b0, 4'd12, 4'd13, 1'b0, "R2");

    // R3: isolated pulse, largest operands, exact latency
    step(1'b1, 4'd15, 4'd15, 1'b0, "R3");
    for (int i = 0; i < 8; i++) step(1'b0, 4'd0, 4'(i), 1'b0, "R3");
    step(1'b1, 4'd1, 4'd0, 1'b0, "R3");
    for (int i = 0; i < 8; i++) step(1'b0, 4'd6, 4'd6, 1'b0, "R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule